// File: doc/BRIEF.md
# Key-Armed 64-Bit Watchdog Timer

This block is a memory-mapped watchdog built around a 64-bit up-counter. The counter and its expiry period are each kept as two 32-bit halves behind a small word-wide register port. Software prepares the block while it is idle. It selects the counting mode, releases both counter halves from reset, clears the counter and loads the period. It then arms the watchdog by writing two fixed 16-bit keys, in order, into the upper half of the watchdog control word.

Once the first key is taken, every configuration register is frozen and the block can no longer be turned off by software. While armed, software restarts the count by writing the same key pair again. If the count reaches the period, or if an unexpected key value arrives while armed, the block raises a one-cycle reset request and a sticky timeout flag. Only the hardware reset input returns the block to idle.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset the request output is low, the timeout flag and the enable bit (control word at offset 0x28, bits 15 and 14) read 0, the counter and period registers read 0, and offset 0x00 reads the ID parameter value.
- R2: While idle, the period halves (0x18 low word, 0x1C high word) read back as written. Offset 0x20 keeps only bits 7:6, the mode field. Offset 0x24 keeps only bits 3:0: bit 0 releases the low counter half, bit 1 releases the high half, and bits 3:2 are the mode select.
- R3: The counter advances by one per cycle only when 0x24 bits 3:2 equal 2, both release bits are 1, and 0x20 bits 7:6 equal 2. A carry out of the low half (offset 0x10) increments the high half (offset 0x14).
- R4: A counter half whose release bit is 0 reads zero and ignores writes. The other half is not affected.
- R5: Writing the key 0xA5C6 to bits 31:16 of offset 0x28 with bit 14 set moves the idle block to a pre-armed state. A following write of key 0xDA7E arms it and restarts the count from zero. A first key without bit 14 set, or the second key while idle, leaves the block idle.
- R6: From the pre-armed state on, writes to offsets 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24 and to bits 15:0 of offset 0x28 are ignored.
- R7: While armed, when the 64-bit count equals {period high, period low}, the flag sets and the request is high for exactly one cycle. This happens P+1 cycles after the arming key is taken, for period P, and repeats every P+1 cycles after that.
- R8: While armed, writing 0xA5C6 and then 0xDA7E restarts the count from zero, so the next expiry again falls P+1 cycles after the second key.
- R9: While armed, a control-word write whose key is not the next expected one raises the flag and a one-cycle request on the cycle after the write.
- R10: Once pre-armed, the block never returns to idle and keeps its enable bit, and the flag stays set, until the hardware reset.
- R11: In the pre-armed state, a write with any key other than 0xDA7E is ignored and raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, combinational |
| wd_rst_req | output | 1 | One-cycle reset request on expiry or key violation |

## Verification
The embedded assertions watch, on every cycle, that the state machine never falls back to idle once it has left it. They also check that the arming state is entered only from the pre-armed or service state, that the flag is sticky and always set together with a request, that a held-in-reset counter half stays at zero, that a stopped counter holds its value, and that locked period writes leave the period alone. Only the bench's scenarios can show the exact expiry distance of P+1 cycles and its repetition, and that a service restarts the count. The same holds for the key-ordering rules, for register readback and field masking, and for the carry between the counter halves.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;

   typedef enum logic [1:0] {
      WD_OFF = 2'd0,
      WD_PRE = 2'd1,
      WD_ON  = 2'd2,
      WD_SVC = 2'd3
   } wd_state_t;

   // register byte offsets
   localparam int unsigned OFS_ID     = 32'h00;
   localparam int unsigned OFS_EMU    = 32'h04;
   localparam int unsigned OFS_CNT_LO = 32'h10;
   localparam int unsigned OFS_CNT_HI = 32'h14;
   localparam int unsigned OFS_PRD_LO = 32'h18;
   localparam int unsigned OFS_PRD_HI = 32'h1C;
   localparam int unsigned OFS_TCTL   = 32'h20;
   localparam int unsigned OFS_GCTL   = 32'h24;
   localparam int unsigned OFS_WCTL   = 32'h28;

   // field positions
   localparam int TMODE_LSB = 6;
   localparam int GMODE_LSB = 2;
   localparam int WEN_BIT   = 14;
   localparam int WFLAG_BIT = 15;
   localparam int KEY_LSB   = 16;

   localparam logic [1:0]  TMODE_CONT = 2'd2;
   localparam logic [1:0]  GMODE_WDOG = 2'd2;
   localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
   localparam logic [15:0] KEY_SECOND = 16'hDA7E;

endpackage

// File: rtl/wdk_counter.sv
`timescale 1ns/1ps
module wdk_counter #(
   parameter int HW = 32,
   parameter int NH = 2,
   localparam int CW = HW * NH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NH-1:0] rel,
   input  logic [NH-1:0] wr,
   input  logic [HW-1:0] wdata,
   input  logic          run,
   input  logic          restart,
   input  logic [CW-1:0] prd,
   output logic [CW-1:0] cnt_q,
   output logic          match
);

   if (HW < 1 || NH < 1) begin : g_bad_geom
      $error("wdk_counter: HW and NH must be positive");
   end

   logic clr;

   assign match = (cnt_q == prd);
   assign clr   = restart | (run & match);

   for (genvar g = 0; g < NH; g++) begin : g_half
      logic [HW-1:0] half_q;
      logic          inc;

      if (g == 0) begin : g_first
         assign inc = run;
      end else begin : g_upper
         assign inc = run & (&cnt_q[g*HW-1:0]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n)         half_q <= '0;
         else if (!rel[g])   half_q <= '0;
         else if (wr[g])     half_q <= wdata;
         else if (clr)       half_q <= '0;
         else if (inc)       half_q <= half_q + 1'b1;
      end

      assign cnt_q[g*HW +: HW] = half_q;

      // R4
      half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rel[g] |=> (half_q == '0));
   end

   // R3
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart && (wr == '0) && (&rel)) |=> $stable(cnt_q));

endmodule

// File: rtl/wdk_fsm.sv
`timescale 1ns/1ps
module wdk_fsm
   import wdk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wctl_wr,
   input  logic [15:0] key,
   input  logic        en_bit,
   input  logic        match,
   output wd_state_t   state,
   output logic        restart,
   output logic        req,
   output logic        flag
);

   wd_state_t nxt;
   logic      viol;
   logic      expire;

   always_comb begin
      nxt     = state;
      restart = 1'b0;
      viol    = 1'b0;
      unique case (state)
         WD_OFF: begin
            if (wctl_wr && key == KEY_FIRST && en_bit) nxt = WD_PRE;
         end
         WD_PRE: begin
            if (wctl_wr && key == KEY_SECOND) begin
               nxt     = WD_ON;
               restart = 1'b1;
            end
         end
         WD_ON: begin
            if (wctl_wr) begin
               if (key == KEY_FIRST) nxt = WD_SVC;
               else                  viol = 1'b1;
            end
         end
         WD_SVC: begin
            if (wctl_wr) begin
               nxt = WD_ON;
               if (key == KEY_SECOND) restart = 1'b1;
               else                   viol = 1'b1;
            end
         end
         default: nxt = WD_OFF;
      endcase
   end

   assign expire = (state == WD_ON || state == WD_SVC) && match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= WD_OFF;
         req   <= 1'b0;
         flag  <= 1'b0;
      end else begin
         state <= nxt;
         req   <= viol | expire;
         flag  <= flag | viol | expire;
      end
   end

   // R10
   never_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != WD_OFF) |=> (state != WD_OFF));

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag |=> flag);

   // R7
   req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> flag);

   // R5
   arm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_ON && $past(state) != WD_ON) |->
         ($past(state) == WD_PRE || $past(state) == WD_SVC));

endmodule

// File: rtl/wdk_regs.sv
`timescale 1ns/1ps
module wdk_regs
   import wdk_pkg::*;
#(
   parameter int          ADDR_W   = 6,
   parameter int          DW       = 32,
   parameter logic [31:0] ID_VALUE = 32'h5744_0001,
   localparam int         CW       = 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              locked,
   input  logic              flag,
   input  logic [CW-1:0]     cnt_q,
   output logic [DW-1:0]     rdata,
   output logic [1:0]        tmode,
   output logic [1:0]        gmode,
   output logic [1:0]        rel,
   output logic [CW-1:0]     prd,
   output logic [1:0]        cnt_wr,
   output logic              wctl_wr
);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("wdk_regs: ADDR_W must cover offset 0x28");
   end
   if (DW < 32) begin : g_bad_dw
      $error("wdk_regs: DW must be at least 32");
   end

   localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
   localparam logic [ADDR_W-1:0] A_EMU  = ADDR_W'(OFS_EMU);
   localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(OFS_CNT_LO);
   localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(OFS_CNT_HI);
   localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(OFS_PRD_LO);
   localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(OFS_PRD_HI);
   localparam logic [ADDR_W-1:0] A_TCTL = ADDR_W'(OFS_TCTL);
   localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(OFS_GCTL);
   localparam logic [ADDR_W-1:0] A_WCTL = ADDR_W'(OFS_WCTL);

   logic [DW-1:0] prd_lo, prd_hi;
   logic          en_q;
   logic          open_wr;

   assign open_wr   = we & ~locked;
   assign cnt_wr[0] = open_wr && addr == A_CLO;
   assign cnt_wr[1] = open_wr && addr == A_CHI;
   assign wctl_wr   = we && addr == A_WCTL;
   assign prd       = {prd_hi, prd_lo};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prd_lo <= '0;
         prd_hi <= '0;
         tmode  <= '0;
         gmode  <= '0;
         rel    <= '0;
         en_q   <= 1'b0;
      end else if (open_wr) begin
         if (addr == A_PLO)  prd_lo <= wdata;
         if (addr == A_PHI)  prd_hi <= wdata;
         if (addr == A_TCTL) tmode  <= wdata[TMODE_LSB +: 2];
         if (addr == A_GCTL) begin
            rel   <= wdata[1:0];
            gmode <= wdata[GMODE_LSB +: 2];
         end
         if (addr == A_WCTL) en_q <= wdata[WEN_BIT];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_ID:   rdata = DW'(ID_VALUE);
         A_EMU:  rdata = '0;
         A_CLO:  rdata = cnt_q[DW-1:0];
         A_CHI:  rdata = cnt_q[CW-1:DW];
         A_PLO:  rdata = prd_lo;
         A_PHI:  rdata = prd_hi;
         A_TCTL: rdata[TMODE_LSB +: 2] = tmode;
         A_GCTL: begin
            rdata[1:0]           = rel;
            rdata[GMODE_LSB +: 2] = gmode;
         end
         A_WCTL: begin
            rdata[WFLAG_BIT] = flag;
            rdata[WEN_BIT]   = en_q;
         end
         default: rdata = '0;
      endcase
   end

   // R6
   lock_prd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && we && (addr == A_PLO || addr == A_PHI)) |=> $stable(prd));

   // R6
   lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && we) |=> ($stable(tmode) && $stable(gmode) && $stable(rel) && $stable(en_q)));

endmodule

// File: rtl/wdk_watchdog.sv
`timescale 1ns/1ps
module wdk_watchdog
   import wdk_pkg::*;
#(
   parameter int          ADDR_W   = 6,
   parameter int          DW       = 32,
   parameter logic [31:0] ID_VALUE = 32'h5744_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              wd_rst_req
);

   localparam int CW = 2 * DW;

   wd_state_t     state;
   logic          restart, flag, match, run, wctl_wr;
   logic [1:0]    tmode, gmode, rel, cnt_wr;
   logic [CW-1:0] prd, cnt_q;

   assign run = (gmode == GMODE_WDOG) && (&rel) && (tmode == TMODE_CONT);

   wdk_regs #(.ADDR_W(ADDR_W), .DW(DW), .ID_VALUE(ID_VALUE)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .locked  (state != WD_OFF),
      .flag    (flag),
      .cnt_q   (cnt_q),
      .rdata   (reg_rdata),
      .tmode   (tmode),
      .gmode   (gmode),
      .rel     (rel),
      .prd     (prd),
      .cnt_wr  (cnt_wr),
      .wctl_wr (wctl_wr)
   );

   wdk_counter #(.HW(DW), .NH(2)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .rel     (rel),
      .wr      (cnt_wr),
      .wdata   (reg_wdata),
      .run     (run),
      .restart (restart),
      .prd     (prd),
      .cnt_q   (cnt_q),
      .match   (match)
   );

   wdk_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wctl_wr (wctl_wr),
      .key     (reg_wdata[KEY_LSB +: 16]),
      .en_bit  (reg_wdata[WEN_BIT]),
      .match   (match),
      .state   (state),
      .restart (restart),
      .req     (wd_rst_req),
      .flag    (flag)
   );

endmodule

// File: tb/sim_wdk_watchdog.sv
`timescale 1ns/1ps
module sim_wdk_watchdog;

   localparam logic [5:0] A_ID = 6'h00, A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18,
                          A_PHI = 6'h1C, A_TCTL = 6'h20, A_GCTL = 6'h24, A_WCTL = 6'h28;
   localparam logic [31:0] ARM1 = 32'hA5C6_4000, ARM2 = 32'hDA7E_4000;

   logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        req;
   int          errs = 0, checks = 0;

   always #2.5 clk = ~clk;

   wdk_watchdog u0 (.clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
                    .reg_wdata(wdata), .reg_rdata(rdata), .wd_rst_req(req));

   function automatic int exp_expiry(input int p);
      return p + 1;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_req(input int maxn, output int n);
      n = 0;
      for (int i = 1; i <= maxn; i++) begin
         @(negedge clk);
         if (req) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg(input logic [31:0] hi, input logic [31:0] lo);
      wr(A_GCTL, 32'h0000_000B);
      wr(A_TCTL, 32'h0000_0080);
      wr(A_CLO, 32'h0);
      wr(A_CHI, 32'h0);
      wr(A_PLO, lo);
      wr(A_PHI, hi);
   endtask

   initial begin
      #(5 * 150000);
      errs++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] v, v2;
      int n, p, d, bad;
      void'($urandom(32'd2024));

      // R1 reset state
      do_reset();
      chk("R1 req", {63'd0, req}, 64'd0);
      rd(A_ID, v);   chk("R1 id", {32'd0, v}, 64'h5744_0001);
      rd(A_WCTL, v); chk("R1 wctl", {32'd0, v}, 64'd0);
      rd(A_CLO, v);  chk("R1 cnt", {32'd0, v}, 64'd0);
      rd(A_PLO, v);  chk("R1 prd", {32'd0, v}, 64'd0);

      // R2 readback and field masks
      wr(A_PLO, 32'h1234_5678); wr(A_PHI, 32'h9ABC_DEF0);
      rd(A_PLO, v); rd(A_PHI, v2);
      chk("R2 period", {v2, v}, 64'h9ABC_DEF0_1234_5678);
      wr(A_TCTL, 32'hFFFF_FFFF); rd(A_TCTL, v); chk("R2 tctl mask", {32'd0, v}, 64'hC0);
      wr(A_GCTL, 32'hFFFF_FFFF); rd(A_GCTL, v); chk("R2 gctl mask", {32'd0, v}, 64'hF);

      // R3 counting conditions
      wr(A_GCTL, 32'hB); wr(A_TCTL, 32'h40); wr(A_CLO, 32'd7);
      repeat (5) @(negedge clk);
      rd(A_CLO, v); chk("R3 one-shot stopped", {32'd0, v}, 64'd7);
      wr(A_GCTL, 32'h7); wr(A_TCTL, 32'h80);
      repeat (5) @(negedge clk);
      rd(A_CLO, v); chk("R3 wrong gmode stopped", {32'd0, v}, 64'd7);
      wr(A_GCTL, 32'hB);
      repeat (5) @(negedge clk);
      rd(A_CLO, v); chk("R3 counting", {32'd0, v}, 64'd12);
      wr(A_CLO, 32'hFFFF_FFFE);
      repeat (3) @(negedge clk);
      rd(A_CHI, v2); rd(A_CLO, v);
      chk("R3 carry", {v2, v}, 64'h1_0000_0001);

      // R4 half reset
      wr(A_GCTL, 32'hA);
      @(negedge clk);
      rd(A_CLO, v); chk("R4 low held", {32'd0, v}, 64'd0);
      wr(A_CLO, 32'd5); rd(A_CLO, v); chk("R4 low write ignored", {32'd0, v}, 64'd0);
      wr(A_CHI, 32'd3); rd(A_CHI, v); chk("R4 high independent", {32'd0, v}, 64'd3);
      wr(A_GCTL, 32'h9);
      @(negedge clk);
      rd(A_CHI, v); chk("R4 high held", {32'd0, v}, 64'd0);

      // R5 wrong arming attempts leave block idle
      do_reset();
      cfg(32'd0, 32'd20);
      wr(A_WCTL, 32'hA5C6_0000);
      wr(A_WCTL, ARM2);
      wait_req(60, n); chk("R5 not armed", n, 0);
      rd(A_WCTL, v); chk("R5 still idle en", {32'd0, v}, 64'h4000);

      // R7 expiry distance and repetition
      do_reset();
      cfg(32'd0, 32'd25);
      wr(A_WCTL, ARM1); wr(A_WCTL, ARM2);
      wait_req(200, n); chk("R7 first expiry", n, exp_expiry(25));
      @(negedge clk); chk("R7 one-cycle pulse", {63'd0, req}, 64'd0);
      rd(A_WCTL, v); chk("R7 flag", {63'd0, v[15]}, 64'd1);
      wait_req(200, n); chk("R7 repeat", n, exp_expiry(25) - 1);

      // R7 64-bit compare: high period word blocks an early match
      do_reset();
      cfg(32'd1, 32'd10);
      wr(A_WCTL, ARM1); wr(A_WCTL, ARM2);
      wait_req(40, n); chk("R7 high word compared", n, 0);

      // R8 random service timing
      for (int it = 0; it < 6; it++) begin
         p = $urandom_range(40, 8);
         d = $urandom_range(p - 5, 0);
         do_reset();
         cfg(32'd0, p);
         wr(A_WCTL, ARM1); wr(A_WCTL, ARM2);
         bad = 0;
         for (int k = 0; k < d; k++) begin
            @(negedge clk);
            if (req) bad++;
         end
         chk("R8 quiet before service", bad, 0);
         wr(A_WCTL, 32'hA5C6_0000); wr(A_WCTL, 32'hDA7E_0000);
         wait_req(p + 10, n); chk("R8 restart after service", n, exp_expiry(p));
      end

      // R6 R11 pre-armed lock and key filtering
      do_reset();
      cfg(32'd0, 32'd30);
      wr(A_WCTL, ARM1);
      wr(A_PLO, 32'd5); wr(A_TCTL, 32'h0); wr(A_GCTL, 32'h0);
      wr(A_WCTL, 32'h1234_0000);
      chk("R11 no request", {63'd0, req}, 64'd0);
      rd(A_PLO, v);  chk("R6 period locked", {32'd0, v}, 64'd30);
      rd(A_TCTL, v); chk("R6 tctl locked", {32'd0, v}, 64'h80);
      rd(A_GCTL, v); chk("R6 gctl locked", {32'd0, v}, 64'hB);
      rd(A_WCTL, v); chk("R6 enable locked", {32'd0, v}, 64'h4000);
      wr(A_WCTL, ARM2);
      wait_req(100, n); chk("R11 arms after ignored key", n, exp_expiry(30));

      // R10 cannot disable once armed
      do_reset();
      cfg(32'd0, 32'd40);
      wr(A_WCTL, ARM1); wr(A_WCTL, ARM2);
      wr(A_WCTL, 32'hA5C6_0000); wr(A_WCTL, 32'hDA7E_0000);
      wait_req(100, n); chk("R10 still times out", n, exp_expiry(40));
      rd(A_WCTL, v); chk("R10 enable kept", {63'd0, v[14]}, 64'd1);

      // R9 key violations
      do_reset();
      cfg(32'd0, 32'd1000);
      wr(A_WCTL, ARM1); wr(A_WCTL, ARM2);
      wr(A_WCTL, 32'h1111_4000);
      chk("R9 active violation", {63'd0, req}, 64'd1);
      @(negedge clk); chk("R9 single pulse", {63'd0, req}, 64'd0);
      wr(A_WCTL, 32'hA5C6_0000); wr(A_WCTL, 32'h0000_0000);
      chk("R9 service violation", {63'd0, req}, 64'd1);
      repeat (50) @(negedge clk);
      rd(A_WCTL, v); chk("R10 flag sticky", {32'd0, v}, 64'hC000);

      // R1 hardware reset clears flag
      do_reset();
      rd(A_WCTL, v); chk("R1 flag cleared", {32'd0, v}, 64'd0);
      chk("R1 req after reset", {63'd0, req}, 64'd0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule